// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This unit sits beside the register file of a 32-bit RISC pipeline. For every single-register load or store it works out the address that goes to memory and the new value of the base register. It handles two instruction layouts. The word/byte layout takes either a 12-bit immediate or an index register moved by a barrel shifter. The halfword/signed layout takes either an 8-bit immediate split across two nibbles or an unshifted index register.

The caller supplies the instruction word, the base and index register values already read from the register file, and the address of the instruction. The unit decodes the offset and its sign, and it applies pre- or post-indexing. It then reports whether the base register has to be written back, and with which value.

All results are captured in one output register stage, together with a valid flag. A result therefore appears exactly one clock after the instruction is presented.

Top module: `ls_addr_unit`

## Requirements
- R1: In the word/byte layout, bit 25 = 0 selects an unsigned 12-bit immediate offset taken from bits 11:0.
- R2: In the word/byte layout, bit 25 = 1 selects the index register named by bits 3:0. It is shifted by the amount in bits 11:7 using the type in bits 6:5 (00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right). An amount of zero leaves the value unshifted.
- R3: Bit 23 set adds the offset to the base and bit 23 clear subtracts it. All sums wrap modulo 2^32.
- R4: In the halfword layout, bit 22 = 1 selects the immediate {bits 11:8, bits 3:0}. Bit 22 = 0 selects the index register value with no shift, whatever bits 11:8 and 6:5 hold.
- R5: With bit 24 set (pre-indexed), the memory address is the offset base. The base is written back with that address only when bit 21 is set.
- R6: With bit 24 clear (post-indexed), the memory address is the unmodified base. The base is always written back with base plus or minus the offset.
- R7: A base field (bits 19:16) or index field (bits 3:0) equal to 15 reads as the instruction address plus 8, in place of the supplied register value.
- R8: Bits 27:26 = 01 select the word/byte layout. Any other value selects the halfword layout.
- R9: Results appear one clock after a cycle with `in_valid` high. `out_valid` is high in exactly those cycles. `wb_reg` carries bits 19:16, `data_reg` carries bits 15:12 and `is_load` carries bit 20.
- R10: Synchronous reset clears `out_valid`, `wb_en` and every result output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| instr | input | 32 | Instruction word |
| base_val | input | 32 | Value of the register named by bits 19:16 |
| index_val | input | 32 | Value of the register named by bits 3:0 |
| pc_val | input | 32 | Address of the instruction |
| out_valid | output | 1 | Results below are valid |
| mem_addr | output | 32 | Effective memory address |
| wb_en | output | 1 | Base register must be written back |
| wb_data | output | 32 | Value to write to the base register |
| wb_reg | output | 4 | Base register number |
| data_reg | output | 4 | Transfer data register number |
| is_load | output | 1 | 1 for a load, 0 for a store |

## Verification
The assertions assume that `in_valid` is low while reset is applied. They also assume the operand inputs are stable for the whole cycle in which `in_valid` is high, because the checks compare registered results against the values held in that previous cycle. The bench drives every vector at the falling clock edge, drops `in_valid` after each one and holds it low during reset, so both conditions always hold. The sweeps also cover shift amounts of zero and offsets that wrap past zero, which exercises the skip-shift rule and modulo arithmetic without any carry-out assumption.

// File: rtl/ls_addr_pkg.sv
package ls_addr_pkg;

    localparam int XLEN      = 32;
    localparam int REG_W     = 4;
    localparam int IMM_W     = 12;
    localparam int SHAMT_W   = 5;
    localparam int PC_AHEAD  = 8;
    localparam logic [REG_W-1:0] PC_REG = '1;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic              word_fmt;
        logic              pre_idx;
        logic              add_dir;
        logic              wback;
        logic              load;
        logic              imm_sel;
        logic [IMM_W-1:0]  imm;
        shift_kind_e       sh_kind;
        logic [SHAMT_W-1:0] sh_amt;
        logic [REG_W-1:0]  base_idx;
        logic [REG_W-1:0]  data_idx;
        logic [REG_W-1:0]  off_idx;
    } ls_fields_t;

    function automatic logic [XLEN-1:0] pc_operand(input logic [XLEN-1:0] pc);
        return pc + XLEN'(PC_AHEAD);
    endfunction

endpackage

// File: rtl/ls_decode.sv
module ls_decode
    import ls_addr_pkg::*;
(
    input  logic [31:0] instr,
    output ls_fields_t  fields
);
    logic unused_cond;
    assign unused_cond = ^instr[31:28];

    always_comb begin
        fields          = '0;
        fields.word_fmt = (instr[27:26] == 2'b01);
        fields.pre_idx  = instr[24];
        fields.add_dir  = instr[23];
        fields.wback    = instr[21];
        fields.load     = instr[20];
        fields.base_idx = instr[19:16];
        fields.data_idx = instr[15:12];
        fields.off_idx  = instr[3:0];
        fields.sh_kind  = shift_kind_e'(instr[6:5]);
        fields.sh_amt   = instr[11:7];
        if (fields.word_fmt) begin
            fields.imm_sel = ~instr[25];
            fields.imm     = instr[11:0];
        end else begin
            fields.imm_sel = instr[22];
            fields.imm     = {4'b0000, instr[11:8], instr[3:0]};
        end
    end
endmodule

// File: rtl/ls_shifter.sv
module ls_shifter
    import ls_addr_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0]       value,
    input  shift_kind_e        kind,
    input  logic [SHAMT_W-1:0] amount,
    output logic [W-1:0]       result
);
    always_comb begin
        if (amount == '0) begin
            result = value;
        end else begin
            unique case (kind)
                SH_LSL: result = value << amount;
                SH_LSR: result = value >> amount;
                SH_ASR: result = W'($signed(value) >>> amount);
                default: result = (value >> amount) | (value << (W - int'(amount)));
            endcase
        end
    end
endmodule

// File: rtl/ls_operands.sv
module ls_operands
    import ls_addr_pkg::*;
#(
    parameter int W = XLEN
) (
    input  ls_fields_t   fields,
    input  logic [W-1:0] base_val,
    input  logic [W-1:0] index_val,
    input  logic [W-1:0] pc_val,
    output logic [W-1:0] base_op,
    output logic [W-1:0] offset
);
    logic [W-1:0] pc_read;
    logic [W-1:0] index_op;
    logic [W-1:0] shifted;

    assign pc_read  = pc_operand(pc_val);
    assign base_op  = (fields.base_idx == PC_REG) ? pc_read : base_val;
    assign index_op = (fields.off_idx  == PC_REG) ? pc_read : index_val;

    ls_shifter #(.W(W)) u_shift (
        .value  (index_op),
        .kind   (fields.sh_kind),
        .amount (fields.sh_amt),
        .result (shifted)
    );

    always_comb begin
        if (fields.imm_sel)
            offset = {{(W-IMM_W){1'b0}}, fields.imm};
        else if (fields.word_fmt)
            offset = shifted;
        else
            offset = index_op;
    end
endmodule

// File: rtl/ls_addr_calc.sv
module ls_addr_calc
    import ls_addr_pkg::*;
#(
    parameter int W = XLEN
) (
    input  ls_fields_t   fields,
    input  logic [W-1:0] base_op,
    input  logic [W-1:0] offset,
    output logic [W-1:0] addr,
    output logic [W-1:0] new_base,
    output logic         wb_needed
);
    assign new_base  = fields.add_dir ? (base_op + offset) : (base_op - offset);
    assign addr      = fields.pre_idx ? new_base : base_op;
    assign wb_needed = ~fields.pre_idx | fields.wback;
endmodule

// File: rtl/ls_addr_unit.sv
module ls_addr_unit
    import ls_addr_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [31:0]  instr,
    input  logic [W-1:0] base_val,
    input  logic [W-1:0] index_val,
    input  logic [W-1:0] pc_val,
    output logic         out_valid,
    output logic [W-1:0] mem_addr,
    output logic         wb_en,
    output logic [W-1:0] wb_data,
    output logic [3:0]   wb_reg,
    output logic [3:0]   data_reg,
    output logic         is_load
);
    ls_fields_t   fields;
    logic [W-1:0] base_op;
    logic [W-1:0] offset;
    logic [W-1:0] addr_c;
    logic [W-1:0] new_base_c;
    logic         wb_c;

    ls_decode u_dec (
        .instr  (instr),
        .fields (fields)
    );

    ls_operands #(.W(W)) u_ops (
        .fields    (fields),
        .base_val  (base_val),
        .index_val (index_val),
        .pc_val    (pc_val),
        .base_op   (base_op),
        .offset    (offset)
    );

    ls_addr_calc #(.W(W)) u_calc (
        .fields    (fields),
        .base_op   (base_op),
        .offset    (offset),
        .addr      (addr_c),
        .new_base  (new_base_c),
        .wb_needed (wb_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            mem_addr  <= '0;
            wb_en     <= 1'b0;
            wb_data   <= '0;
            wb_reg    <= '0;
            data_reg  <= '0;
            is_load   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                mem_addr <= addr_c;
                wb_en    <= wb_c;
                wb_data  <= new_base_c;
                wb_reg   <= fields.base_idx;
                data_reg <= fields.data_idx;
                is_load  <= fields.load;
            end
        end
    end

    // R9: result valid exactly one clock after the request
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r9_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R6: post-indexed access uses the untouched base and always writes back
    a_r6_post_uses_base: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !instr[24]) |=> (wb_en && mem_addr == $past(base_op)));

    // R5: pre-indexed without the writeback bit leaves the base alone
    a_r5_pre_no_wb: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[24] && !instr[21]) |=> !wb_en);

    // R5: pre-indexed with writeback stores the accessed address
    a_r5_pre_wb_equal: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[24] && instr[21]) |=> (wb_en && wb_data == mem_addr));

    // R3: a zero offset leaves the base value unchanged in either direction
    a_r3_zero_offset: assert property (@(posedge clk) disable iff (rst)
        (in_valid && offset == '0) |=> (wb_data == $past(base_op)));
endmodule

// File: tb/test_ls_addr_unit.sv
module test_ls_addr_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] base_val = '0;
    logic [31:0] index_val = '0;
    logic [31:0] pc_val = '0;
    logic        out_valid;
    logic [31:0] mem_addr;
    logic        wb_en;
    logic [31:0] wb_data;
    logic [3:0]  wb_reg;
    logic [3:0]  data_reg;
    logic        is_load;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    ls_addr_unit i_ls_addr_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .base_val(base_val), .index_val(index_val), .pc_val(pc_val),
        .out_valid(out_valid), .mem_addr(mem_addr), .wb_en(wb_en),
        .wb_data(wb_data), .wb_reg(wb_reg), .data_reg(data_reg), .is_load(is_load)
    );

    function automatic logic [31:0] model_shift(input logic [31:0] v, input logic [1:0] t,
                                                input logic [4:0] a);
        logic [63:0] dbl;
        if (a == 0) return v;
        case (t)
            2'd0: return v << a;
            2'd1: return v >> a;
            2'd2: return 32'($signed(v) >>> a);
            default: begin
                dbl = {v, v} >> a;
                return dbl[31:0];
            end
        endcase
    endfunction

    task automatic check(input string tag, input logic ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run(input string tag, input logic [31:0] ins, input logic [31:0] b,
                       input logic [31:0] x, input logic [31:0] p);
        logic [31:0] bop, xop, off, sum, e_addr;
        logic        e_wb;
        @(negedge clk);
        instr = ins; base_val = b; index_val = x; pc_val = p; in_valid = 1'b1;
        bop = (ins[19:16] == 4'd15) ? p + 32'd8 : b;
        xop = (ins[3:0]   == 4'd15) ? p + 32'd8 : x;
        if (ins[27:26] == 2'b01)
            off = ins[25] ? model_shift(xop, ins[6:5], ins[11:7]) : {20'd0, ins[11:0]};
        else
            off = ins[22] ? {24'd0, ins[11:8], ins[3:0]} : xop;
        sum    = ins[23] ? bop + off : bop - off;
        e_addr = ins[24] ? sum : bop;
        e_wb   = !ins[24] || ins[21];
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, out_valid && wb_en == e_wb && wb_reg == ins[19:16] &&
              data_reg == ins[15:12] && is_load == ins[20],
              "ctl", {24'd0, out_valid, wb_en, is_load, 1'b0, wb_reg},
              {24'd0, 1'b1, e_wb, ins[20], 1'b0, ins[19:16]});
        check(tag, mem_addr == e_addr, "addr", mem_addr, e_addr);
        check(tag, wb_data == sum, "wbdata", wb_data, sum);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] imms [5];
        imms = '{32'h0, 32'h1, 32'h7FF, 32'hFFF, 32'h5A4};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset values
        check("R10", !out_valid && !wb_en && mem_addr == 0 && wb_data == 0 &&
              wb_reg == 0 && data_reg == 0 && !is_load, "reset", mem_addr, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R9", !out_valid, "idle valid", {31'd0, out_valid}, 32'd0);

        // R1, R3, R5, R6: word immediate over all P/U/W/L combinations
        for (int k = 0; k < 5; k++)
            for (int c = 0; c < 16; c++)
                run("R1", {4'hE, 2'b01, 1'b0, c[3], c[2], 1'b0, c[1], c[0],
                           4'(k + 2), 4'(c), imms[k][11:0]},
                    (k == 1) ? 32'h0 : $urandom, $urandom, 32'h1000);

        // R2: every shift type and amount, both directions
        for (int t = 0; t < 4; t++)
            for (int a = 0; a < 32; a++)
                for (int u = 0; u < 2; u++)
                    run("R2", {4'hE, 2'b01, 1'b1, 1'b1, u[0], 1'b0, 1'b1, 1'b1,
                               4'd3, 4'd4, 5'(a), 2'(t), 1'b0, 4'd6},
                        $urandom, (a[0]) ? 32'h8000_0001 : $urandom, 32'h2000);

        // R4: halfword split immediate, every nibble pair
        for (int hi = 0; hi < 16; hi++)
            for (int lo = 0; lo < 16; lo++)
                run("R4", {4'hE, 3'b000, lo[0], hi[0], 1'b1, hi[1], lo[1],
                           4'd5, 4'd1, 4'(hi), 4'b1011, 4'(lo)},
                    $urandom, 32'hFFFF_FFFF, 32'h3000);

        // R4: halfword register offset ignores bits 11:8 and 6:5
        for (int g = 0; g < 32; g++)
            run("R4", {4'hE, 3'b000, g[0], g[1], 1'b0, g[2], 1'b1,
                       4'd7, 4'd8, 4'(g * 5), 1'b1, 2'(g), 1'b1, 4'd9},
                $urandom, $urandom, 32'h3000);

        // R3: wrap below zero and above 2^32
        run("R3", {4'hE, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 4'd2, 12'h010},
            32'h0000_0004, 32'h0, 32'h0);
        run("R3", {4'hE, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1, 4'd2, 8'h00, 4'd3},
            32'hFFFF_FFF0, 32'h0000_0020, 32'h0);

        // R7: register 15 as base or index
        for (int v = 0; v < 8; v++) begin
            run("R7", {4'hE, 2'b01, 1'b1, v[0], v[1], 1'b0, 1'b0, 1'b1,
                       4'd15, 4'd0, 5'd2, 2'b00, 1'b0, 4'd15},
                32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h0000_4000 + 32'(v * 4));
            run("R7", {4'hE, 3'b000, v[0], v[1], 1'b0, 1'b1, 1'b1,
                       4'd2, 4'd0, 4'd0, 4'b1011, 4'd15},
                32'h100, 32'h1234_5678, 32'h0000_8000 + 32'(v * 4));
        end

        // R8: layout select for each value of bits 27:26
        for (int f = 0; f < 4; f++)
            for (int r = 0; r < 4; r++)
                run("R8", {4'hE, 2'(f), 1'b1, 1'b1, r[0], r[1], 1'b1, 1'b0,
                           4'd6, 4'd3, 4'h2, 4'b1101, 4'd4},
                    $urandom, $urandom, 32'h0);

        // R9: valid drops when no request follows
        @(negedge clk);
        check("R9", !out_valid, "valid after gap", {31'd0, out_valid}, 32'd0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule